// File: doc/BRIEF.md
# Carrier-Clocked Manchester / Biphase Line Coder

This block turns a serial stream of data bits into the on/off control for a load modulator. All timing is counted in cycles of the carrier clock. A bit lasts 64 or 32 carrier cycles, as chosen by a rate input. The mid-bit point falls after half of that count. One coding engine serves both Manchester and biphase coding, and a mode input picks between them.

The serializer feeding the block sees a one-cycle request just before each bit boundary. It shifts its next bit onto `bit_in` on the clock edge that samples that request, so the bit is stable when the boundary edge captures it. The coding mode and rate are taken at the same boundary edge and hold for the whole bit that follows. The output is a switch command, not a logic level: a high coded level leaves the modulator switch off, and a low coded level turns it on.

Top module: `carrier_line_coder`

## Requirements
- R1: While `rst_n` is low, and after its release until the first bit boundary, `mod_on` is 0 (switch off, coded level high). The first boundary comes two cycles after reset release.
- R2: A bit captured with `rate_sel`=0 lasts 64 clock cycles, and with `rate_sel`=1 it lasts 32. Its mid-bit change point is exactly half of that count after the boundary.
- R3: In Manchester mode (`code_sel`=0), a bit value 1 gives coded level high for the first half. A 0 gives coded level low for the first half.
- R4: In Manchester mode the coded level always inverts at mid-bit.
- R5: In biphase mode (`code_sel`=1), the coded level inverts at the start of every bit.
- R6: In biphase mode a bit value 1 holds its level through mid-bit, and a 0 inverts the level at mid-bit.
- R7: `mod_on` is the inverse of the coded level: 1 means switch on (coded low), 0 means switch off (coded high). It changes only on the clock edge that ends a boundary or mid-bit cycle.
- R8: `bit_req` is high for exactly one cycle per bit, the cycle two before the new bit's first output cycle. The bit present on `bit_in` in the following cycle is the one coded next.
- R9: `bit_in`, `code_sel` and `rate_sel` are ignored in every cycle except the one that ends at a bit boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_in | input | 1 | Next data bit from the serializer |
| code_sel | input | 1 | 0 = Manchester, 1 = biphase |
| rate_sel | input | 1 | 0 = 64 cycles per bit, 1 = 32 cycles per bit |
| mod_on | output | 1 | Modulator switch command, 1 = switch on |
| bit_req | output | 1 | One-cycle request for the next bit |

## Verification
A bit captured at a boundary edge shows its first-half level from the very next cycle. Its second-half level appears half a period later, and the next request comes in the bit's second-to-last cycle. `bit_req` and `mod_on` are both registered-state outputs, so every result is due one edge after the state changes. The bench builds a queue of expected levels with one entry per cycle, appending a whole bit when it answers a request. It compares the head of the queue on each falling edge, which falls inside the cycle in which the value is due. Outside the boundary cycle the bench drives random values on all three inputs. Any sampling at the wrong time therefore shows up as a miscompare.

// File: rtl/lc_pkg.sv
package lc_pkg;

  typedef enum logic {
    CODE_MANCH = 1'b0,
    CODE_BIPH  = 1'b1
  } code_t;

  // index of the final cycle of a bit for the selected rate
  function automatic int last_count(int slow, int fast, logic fast_sel);
    return (fast_sel ? fast : slow) - 1;
  endfunction

  // index of the final cycle of the first half-bit
  function automatic int mid_count(int last);
    return last / 2;
  endfunction

  // coded level for the first half of a new bit
  function automatic logic first_half(code_t c, logic b, logic prev);
    return (c == CODE_MANCH) ? b : !prev;
  endfunction

  // coded level for the second half of the bit
  function automatic logic second_half(code_t c, logic b, logic first);
    return (c == CODE_MANCH) ? !first : (b ? first : !first);
  endfunction

endpackage

// File: rtl/lc_bit_timer.sv
module lc_bit_timer #(
  parameter int RATE_SLOW = 64,
  parameter int RATE_FAST = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rate_sel,
  output logic at_bnd,
  output logic at_mid,
  output logic bit_req
);
  import lc_pkg::*;

  localparam int CNT_W = $clog2(RATE_SLOW);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last_q;

  assign at_bnd  = (int'(cnt) == int'(last_q));
  assign at_mid  = (int'(cnt) == mid_count(int'(last_q)));
  assign bit_req = (int'(cnt) == int'(last_q) - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q <= CNT_W'(RATE_SLOW - 1);
      cnt    <= CNT_W'(RATE_SLOW - 2);
    end else if (at_bnd) begin
      last_q <= CNT_W'(last_count(RATE_SLOW, RATE_FAST, rate_sel));
      cnt    <= '0;
    end else begin
      cnt    <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/lc_level_shaper.sv
module lc_level_shaper (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          at_bnd,
  input  logic          at_mid,
  input  logic          bit_in,
  input  logic          code_sel,
  output lc_pkg::code_t mode_q,
  output logic          bit_q,
  output logic          level_q
);
  import lc_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= CODE_MANCH;
      bit_q   <= 1'b1;
      level_q <= 1'b1;
    end else if (at_bnd) begin
      mode_q  <= code_t'(code_sel);
      bit_q   <= bit_in;
      level_q <= first_half(code_t'(code_sel), bit_in, level_q);
    end else if (at_mid) begin
      level_q <= second_half(mode_q, bit_q, level_q);
    end
  end

endmodule

// File: rtl/carrier_line_coder.sv
module carrier_line_coder #(
  parameter int RATE_SLOW = 64,
  parameter int RATE_FAST = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_in,
  input  logic code_sel,
  input  logic rate_sel,
  output logic mod_on,
  output logic bit_req
);
  import lc_pkg::*;

  logic  at_bnd;
  logic  at_mid;
  code_t mode_q;
  logic  bit_q;
  logic  level_q;

  lc_bit_timer #(
    .RATE_SLOW(RATE_SLOW),
    .RATE_FAST(RATE_FAST)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .rate_sel(rate_sel),
    .at_bnd  (at_bnd),
    .at_mid  (at_mid),
    .bit_req (bit_req)
  );

  lc_level_shaper u_shape (
    .clk     (clk),
    .rst_n   (rst_n),
    .at_bnd  (at_bnd),
    .at_mid  (at_mid),
    .bit_in  (bit_in),
    .code_sel(code_sel),
    .mode_q  (mode_q),
    .bit_q   (bit_q),
    .level_q (level_q)
  );

  // high coded level = switch off
  assign mod_on = !level_q;

endmodule

// File: rtl/lc_coder_chk.sv
module lc_coder_chk (
  input logic          clk,
  input logic          rst_n,
  input logic          bit_in,
  input logic          code_sel,
  input logic          mod_on,
  input logic          bit_req,
  input logic          at_bnd,
  input logic          at_mid,
  input lc_pkg::code_t mode_q,
  input logic          bit_q
);
  import lc_pkg::*;

  p_req_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bit_req |=> !bit_req);

  p_req_then_bnd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bit_req |=> at_bnd);

  p_quiet_between_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!at_bnd && !at_mid) |=> $stable(mod_on));

  p_manch_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (at_bnd && code_sel == 1'b0) |=> (mod_on == !$past(bit_in)));

  p_manch_mid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (at_mid && mode_q == CODE_MANCH) |=> (mod_on != $past(mod_on)));

  p_biph_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (at_bnd && code_sel == 1'b1) |=> (mod_on != $past(mod_on)));

  p_biph_one_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (at_mid && mode_q == CODE_BIPH && bit_q) |=> $stable(mod_on));

  p_biph_zero_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (at_mid && mode_q == CODE_BIPH && !bit_q) |=> (mod_on != $past(mod_on)));

endmodule

bind carrier_line_coder lc_coder_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .bit_in  (bit_in),
  .code_sel(code_sel),
  .mod_on  (mod_on),
  .bit_req (bit_req),
  .at_bnd  (at_bnd),
  .at_mid  (at_mid),
  .mode_q  (mode_q),
  .bit_q   (bit_q)
);

// File: tb/sim_carrier_line_coder.sv
module sim_carrier_line_coder;

  logic clk = 1'b0;
  logic rst_n;
  logic bit_in, code_sel, rate_sel;
  logic mod_on, bit_req;

  always #10 clk = !clk;

  carrier_line_coder u0 (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .code_sel(code_sel),
    .rate_sel(rate_sel), .mod_on(mod_on), .bit_req(bit_req)
  );

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  bit finished = 0;

  logic  exp_lvl[$];
  string exp_tag[$];

  task automatic check(string tag, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %b expected %b", tag, cycles, act, exp);
    end
  endtask

  // append one bit's expected coded levels, cycle by cycle (R2..R6)
  task automatic push_bit(logic b, logic m, logic r);
    int   per;
    logic prev, first, second;
    per   = r ? 32 : 64;
    prev  = exp_lvl[$];
    if (!m) begin first = b;     second = !b; end
    else    begin first = !prev; second = b ? first : !first; end
    for (int i = 0; i < per; i++) begin
      if (i < per / 2) begin
        exp_lvl.push_back(first);
        exp_tag.push_back(m ? "R5 biphase start (R2,R7)" : "R3 manchester first half (R2,R7)");
      end else begin
        exp_lvl.push_back(second);
        exp_tag.push_back(m ? "R6 biphase mid (R2,R7)" : "R4 manchester mid (R2,R7)");
      end
    end
  endtask

  function automatic logic [2:0] pick(int idx);
    logic [15:0] pat;
    logic b, m, r;
    pat = 16'b1100_1010_0111_0001;
    b = pat[idx % 16];
    if      (idx < 16) begin m = 1'b0; r = 1'b0; end
    else if (idx < 32) begin m = 1'b1; r = 1'b1; end
    else if (idx < 40) begin m = 1'b0; r = 1'b1; end
    else if (idx < 48) begin m = 1'b1; r = 1'b0; end
    else begin b = 1'($urandom); m = 1'($urandom); r = 1'($urandom); end
    return {b, m, r};
  endfunction

  initial begin
    while (!finished) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog: actual hung, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [2:0] nxt;
    logic       pending;
    int         sent;
    rst_n = 1'b0; bit_in = 1'b0; code_sel = 1'b1; rate_sel = 1'b1;
    pending = 1'b0; nxt = '0; sent = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R1 reset level", mod_on, 1'b0);
    end
    @(posedge clk); #1;
    rst_n = 1'b1;
    exp_lvl.push_back(1'b1); exp_tag.push_back("R1 pre-boundary");
    exp_lvl.push_back(1'b1); exp_tag.push_back("R1 pre-boundary");
    while (exp_lvl.size() > 0) begin
      logic  lv;
      string tg;
      @(negedge clk);
      lv = exp_lvl.pop_front();
      tg = exp_tag.pop_front();
      check(tg, mod_on, !lv);
      check("R8 request timing", bit_req, exp_lvl.size() == 1);
      if (bit_req && sent < 80) begin
        nxt = pick(sent);
        sent++;
        push_bit(nxt[2], nxt[1], nxt[0]);
        pending = 1'b1;
      end
      @(posedge clk); #1;
      if (pending) begin
        {bit_in, code_sel, rate_sel} = nxt;
        pending = 1'b0;
      end else begin
        // R9: junk outside the boundary cycle must not disturb the output
        bit_in   = 1'($urandom);
        code_sel = 1'($urandom);
        rate_sel = 1'($urandom);
      end
      if (exp_lvl.size() == 1 && sent >= 80) break;
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule